// File: doc/BRIEF.md
# Disk sector address sequencer

This block sits in front of the sector loop of a disk controller. It runs during a multi-sector read, write or read-check. A start pulse loads the command's packed head/sector word, the cylinder the command asks for, and the cylinder the drive currently reports. It also marks the next sector as the first of the run.

Each step pulse asks whether the sector now addressed may be transferred. One cycle later the block answers in one of two ways:
- A go pulse. The linear sector address of the approved sector is captured, and the head/sector word advances to the following sector. Within a track the sector number counts up; at the end of a track it moves to sector 0 of the next surface.
- A done pulse with exactly one error code. The run ends and no address state changes.

The data movement, the seek timing and the storage medium belong to other blocks.

Top module: `sector_addr_seq`

## Requirements
- R1: After reset `go`, `done` and `busy` are 0, `errCode` is 0, and `headSec`, `driveCyl` and `secAddr` are all 0.
- R2: On a step, the run ends with error code 4'b0001 (transfer fault) when `attached` is 0. It also ends with that code when `writeProt` is 1 and `cmd` is the write code 2'b01. With the read code 2'b00 or the read-check code 2'b10, write protection has no effect.
- R3: If the requested cylinder is nonzero and differs from the drive cylinder, a step ends with error code 4'b0010 (cylinder compare fail). `headSec` and `driveCyl` keep their values.
- R4: If the requested cylinder is 0 and the drive cylinder is not, a step sets `driveCyl` to 0 and checking goes on with cylinder 0.
- R5: A sector field (`headSec[3:0]` at default sizes) at or above NUM_SECTORS ends the run with error code 4'b0100 (sector overrun).
- R6: When the step is not the first approved one of the run and head and sector are both 0, the run ends with error code 4'b1000 (cylinder overflow). On the first step, head 0 sector 0 is accepted.
- R7: When several faults apply at once, only the first one in this order is reported: transfer fault, cylinder compare, sector overrun, cylinder overflow. The cylinder-0 forcing of R4 takes effect even when a sector overrun follows.
- R8: After an approved step whose sector is below NUM_SECTORS-1, `headSec` increases by one.
- R9: After an approved step on the last sector of a track, the sector becomes 0 and the head increases by one. From head NUM_HEADS-1 the head wraps to 0.
- R10: With a go pulse, `secAddr` becomes (cylinder*NUM_HEADS + head)*NUM_SECTORS + sector, computed for the approved sector. It holds that value until the next go.
- R11: `go` and `done` are single-cycle pulses registered one cycle after the step and never high together. `errCode` is one-hot while `done` is high and 0 otherwise. A fault clears `busy` and leaves `headSec` and `secAddr` unchanged. A step while `busy` is 0 has no effect.
- R12: The first-sector mark is set by `start` and cleared by the first go. A new `start` sets it again, even in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load a new run; wins over `step` |
| step | input | 1 | Request validation of the current sector |
| cmd | input | 2 | 00 read, 01 write, 10 read-check |
| attached | input | 1 | Drive is present |
| writeProt | input | 1 | Drive is write protected |
| reqCyl | input | 5 | Requested cylinder, loaded on `start` |
| curCyl | input | 5 | Drive's present cylinder, loaded on `start` |
| hsInit | input | 6 | Packed head (upper) / sector (lower) word, loaded on `start` |
| go | output | 1 | Sector approved pulse |
| done | output | 1 | Run ended by a fault |
| errCode | output | 4 | One-hot fault code, valid with `done` |
| headSec | output | 6 | Current packed head/sector word |
| driveCyl | output | 5 | Drive cylinder as tracked by the block |
| busy | output | 1 | A run is active |
| secAddr | output | 10 | Linear address of the last approved sector |

## Verification
The hardest case to reach is the cylinder overflow. It appears only after a run has stepped through every sector of every surface and wrapped back to head 0, sector 0. At that point the first-sector mark has to be clear. The bench starts one run at the origin and issues a back-to-back burst of exactly NUM_HEADS*NUM_SECTORS approved steps, then one more step. It also starts a run on the last sector of the last head, so the wrap and the overflow come just two steps apart. Combined faults are driven deliberately, so that the reporting order and the cylinder forcing under a later sector overrun are both seen.

// File: rtl/secseq_pkg.sv
package secseq_pkg;

  typedef enum logic [1:0] {
    CMD_READ   = 2'd0,
    CMD_WRITE  = 2'd1,
    CMD_VERIFY = 2'd2,
    CMD_SPARE  = 2'd3
  } xfer_cmd_e;

  typedef enum logic [3:0] {
    FLT_NONE   = 4'b0000,
    FLT_XFER   = 4'b0001,
    FLT_CYLCMP = 4'b0010,
    FLT_SECOVR = 4'b0100,
    FLT_CYLOVF = 4'b1000
  } fault_e;

  typedef enum logic {
    SEQ_IDLE   = 1'b0,
    SEQ_ACTIVE = 1'b1
  } seq_state_e;

  // control -> datapath
  typedef struct packed {
    logic load;
    logic forceCyl;
    logic advance;
    logic capture;
  } seq_strobe_t;

  // datapath -> control
  typedef struct packed {
    logic cylDiffers;
    logic reqIsZero;
    logic secBeyond;
    logic atTrackOrigin;
  } seq_flags_t;

endpackage

// File: rtl/secseq_dp.sv
module secseq_dp
  import secseq_pkg::*;
#(
  parameter int NUM_CYLS    = 20,
  parameter int NUM_HEADS   = 4,
  parameter int NUM_SECTORS = 12,
  parameter int SEC_FIELD_W = 4,
  localparam int CYL_W  = $clog2(NUM_CYLS),
  localparam int HEAD_W = $clog2(NUM_HEADS),
  localparam int HS_W   = HEAD_W + SEC_FIELD_W,
  localparam int ADDR_W = $clog2(NUM_CYLS * NUM_HEADS * NUM_SECTORS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       strobe,
  input  logic [HS_W-1:0]   hsInit,
  input  logic [CYL_W-1:0]  reqCylIn,
  input  logic [CYL_W-1:0]  curCylIn,
  output seq_flags_t        flags,
  output logic [HS_W-1:0]   headSec,
  output logic [CYL_W-1:0]  driveCyl,
  output logic [ADDR_W-1:0] secAddr
);

  localparam logic [ADDR_W-1:0] HEADS_A = ADDR_W'(NUM_HEADS);
  localparam logic [ADDR_W-1:0] SECS_A  = ADDR_W'(NUM_SECTORS);

  logic [HS_W-1:0]        hsReg;
  logic [CYL_W-1:0]       reqReg;
  logic [CYL_W-1:0]       drvReg;
  logic [ADDR_W-1:0]      addrReg;

  logic [HEAD_W-1:0]      curHead;
  logic [SEC_FIELD_W-1:0] curSec;
  logic [HEAD_W-1:0]      nextHead;
  logic                   lastSecOfTrack;
  logic [HS_W-1:0]        hsNext;
  logic [CYL_W-1:0]       effCyl;
  logic [ADDR_W-1:0]      linAddr;

  assign curHead = hsReg[SEC_FIELD_W +: HEAD_W];
  assign curSec  = hsReg[SEC_FIELD_W-1:0];

  // sector sequencing within a track and across surfaces
  assign lastSecOfTrack = (int'(curSec) + 1) >= NUM_SECTORS;
  assign nextHead       = (int'(curHead) >= NUM_HEADS - 1) ? '0 : curHead + 1'b1;

  always_comb begin
    if (lastSecOfTrack) hsNext = {nextHead, {SEC_FIELD_W{1'b0}}};
    else                hsNext = hsReg + 1'b1;
  end

  // a differing drive cylinder only survives validation when the request is 0
  assign effCyl  = flags.cylDiffers ? '0 : drvReg;
  assign linAddr = (ADDR_W'(effCyl) * HEADS_A + ADDR_W'(curHead)) * SECS_A
                   + ADDR_W'(curSec);

  always_comb begin
    flags.cylDiffers    = (reqReg != drvReg);
    flags.reqIsZero     = (reqReg == '0);
    flags.secBeyond     = int'(curSec) >= NUM_SECTORS;
    flags.atTrackOrigin = (curHead == '0) && (curSec == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsReg   <= '0;
      reqReg  <= '0;
      drvReg  <= '0;
      addrReg <= '0;
    end else begin
      if (strobe.load) begin
        hsReg  <= hsInit;
        reqReg <= reqCylIn;
        drvReg <= curCylIn;
      end else begin
        if (strobe.forceCyl) drvReg <= '0;
        if (strobe.advance)  hsReg  <= hsNext;
      end
      if (strobe.capture) addrReg <= linAddr;
    end
  end

  assign headSec  = hsReg;
  assign driveCyl = drvReg;
  assign secAddr  = addrReg;

  // R9
  track_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && lastSecOfTrack) |=> (hsReg[SEC_FIELD_W-1:0] == '0));

  // R8
  sector_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !lastSecOfTrack) |=>
      (hsReg[SEC_FIELD_W +: HEAD_W] == $past(hsReg[SEC_FIELD_W +: HEAD_W])));

endmodule

// File: rtl/secseq_ctrl.sv
module secseq_ctrl
  import secseq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        step,
  input  logic [1:0]  cmd,
  input  logic        attached,
  input  logic        writeProt,
  input  seq_flags_t  flags,
  output seq_strobe_t strobe,
  output logic        go,
  output logic        done,
  output logic [3:0]  errCode,
  output logic        busy
);

  seq_state_e state;
  logic       firstReg;
  logic       stepOk;
  logic       xferOk;
  xfer_cmd_e  cmdE;
  fault_e     fault;
  fault_e     faultReg;

  assign cmdE   = xfer_cmd_e'(cmd);
  assign stepOk = step && (state == SEQ_ACTIVE) && !start;
  assign xferOk = attached && !(cmdE == CMD_WRITE && writeProt);

  // fixed reporting order
  always_comb begin
    if (!xferOk)                                  fault = FLT_XFER;
    else if (flags.cylDiffers && !flags.reqIsZero) fault = FLT_CYLCMP;
    else if (flags.secBeyond)                     fault = FLT_SECOVR;
    else if (!firstReg && flags.atTrackOrigin)    fault = FLT_CYLOVF;
    else                                          fault = FLT_NONE;
  end

  always_comb begin
    strobe.load     = start;
    strobe.forceCyl = stepOk && xferOk && flags.cylDiffers && flags.reqIsZero;
    strobe.advance  = stepOk && (fault == FLT_NONE);
    strobe.capture  = stepOk && (fault == FLT_NONE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= SEQ_IDLE;
      firstReg <= 1'b0;
      go       <= 1'b0;
      done     <= 1'b0;
      faultReg <= FLT_NONE;
    end else begin
      go       <= stepOk && (fault == FLT_NONE);
      done     <= stepOk && (fault != FLT_NONE);
      faultReg <= stepOk ? fault : FLT_NONE;
      if (start) begin
        state    <= SEQ_ACTIVE;
        firstReg <= 1'b1;
      end else if (stepOk) begin
        if (fault != FLT_NONE) state    <= SEQ_IDLE;
        else                   firstReg <= 1'b0;
      end
    end
  end

  assign errCode = faultReg;
  assign busy    = (state == SEQ_ACTIVE);

  // R11
  err_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(errCode));

  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(go && done));

  // R11
  done_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (errCode != 4'b0000 && !busy));

  // R12
  first_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    go |-> !firstReg);

  // R6
  overflow_late_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && errCode == FLT_CYLOVF) |-> $past(!firstReg));

endmodule

// File: rtl/sector_addr_seq.sv
module sector_addr_seq
  import secseq_pkg::*;
#(
  parameter int NUM_CYLS    = 20,
  parameter int NUM_HEADS   = 4,
  parameter int NUM_SECTORS = 12,
  parameter int SEC_FIELD_W = 4,
  localparam int CYL_W  = $clog2(NUM_CYLS),
  localparam int HEAD_W = $clog2(NUM_HEADS),
  localparam int HS_W   = HEAD_W + SEC_FIELD_W,
  localparam int ADDR_W = $clog2(NUM_CYLS * NUM_HEADS * NUM_SECTORS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              step,
  input  logic [1:0]        cmd,
  input  logic              attached,
  input  logic              writeProt,
  input  logic [CYL_W-1:0]  reqCyl,
  input  logic [CYL_W-1:0]  curCyl,
  input  logic [HS_W-1:0]   hsInit,
  output logic              go,
  output logic              done,
  output logic [3:0]        errCode,
  output logic [HS_W-1:0]   headSec,
  output logic [CYL_W-1:0]  driveCyl,
  output logic              busy,
  output logic [ADDR_W-1:0] secAddr
);

  seq_strobe_t strobe;
  seq_flags_t  flags;

  secseq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .step      (step),
    .cmd       (cmd),
    .attached  (attached),
    .writeProt (writeProt),
    .flags     (flags),
    .strobe    (strobe),
    .go        (go),
    .done      (done),
    .errCode   (errCode),
    .busy      (busy)
  );

  secseq_dp #(
    .NUM_CYLS    (NUM_CYLS),
    .NUM_HEADS   (NUM_HEADS),
    .NUM_SECTORS (NUM_SECTORS),
    .SEC_FIELD_W (SEC_FIELD_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .hsInit   (hsInit),
    .reqCylIn (reqCyl),
    .curCylIn (curCyl),
    .flags    (flags),
    .headSec  (headSec),
    .driveCyl (driveCyl),
    .secAddr  (secAddr)
  );

  // R11
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (headSec == $past(headSec) && secAddr == $past(secAddr)));

  // R2
  protect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(writeProt && cmd == 2'b01 && attached)) |-> (errCode == 4'b0001));

endmodule

// File: tb/sim_sector_addr_seq.sv
`timescale 1ns/100ps
module sim_sector_addr_seq;

  localparam int CYLS  = 20;
  localparam int HEADS = 4;
  localparam int SECS  = 12;
  localparam int SECW  = 4;
  localparam int CYLW  = 5;
  localparam int HSW   = 6;
  localparam int ADDRW = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, step = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic attached = 1'b0, writeProt = 1'b0;
  logic [CYLW-1:0] reqCyl = '0, curCyl = '0;
  logic [HSW-1:0] hsInit = '0;
  logic go, done, busy;
  logic [3:0] errCode;
  logic [HSW-1:0] headSec;
  logic [CYLW-1:0] driveCyl;
  logic [ADDRW-1:0] secAddr;

  int nCmp = 0;
  int nBad = 0;
  string curReq = "R1";

  always #2 clk = ~clk;

  sector_addr_seq #(
    .NUM_CYLS(CYLS), .NUM_HEADS(HEADS), .NUM_SECTORS(SECS), .SEC_FIELD_W(SECW)
  ) u0 (
    .clk(clk), .rstN(rstN), .start(start), .step(step), .cmd(cmd),
    .attached(attached), .writeProt(writeProt), .reqCyl(reqCyl), .curCyl(curCyl),
    .hsInit(hsInit), .go(go), .done(done), .errCode(errCode), .headSec(headSec),
    .driveCyl(driveCyl), .busy(busy), .secAddr(secAddr)
  );

  // behavioural reference
  int mBusy = 0, mFirst = 0, mHead = 0, mSec = 0, mCyl = 0, mReq = 0;
  int mGo = 0, mDone = 0, mErr = 0, mAddr = 0;

  always @(posedge clk) begin
    int e;
    if (!rstN) begin
      mBusy = 0; mFirst = 0; mHead = 0; mSec = 0; mCyl = 0; mReq = 0;
      mGo = 0; mDone = 0; mErr = 0; mAddr = 0;
    end else begin
      mGo = 0; mDone = 0; mErr = 0;
      if (start) begin
        mBusy = 1; mFirst = 1;
        mHead = int'(hsInit) / (1 << SECW);
        mSec  = int'(hsInit) % (1 << SECW);
        mCyl = int'(curCyl); mReq = int'(reqCyl);
      end else if (step && mBusy != 0) begin
        e = 0;
        if (!attached || (cmd == 2'b01 && writeProt)) e = 1;
        else if (mReq != mCyl && mReq != 0) e = 2;
        else begin
          if (mReq != mCyl) mCyl = 0;
          if (mSec >= SECS) e = 4;
          else if (mFirst == 0 && mHead == 0 && mSec == 0) e = 8;
        end
        if (e != 0) begin
          mDone = 1; mErr = e; mBusy = 0;
        end else begin
          mGo = 1; mFirst = 0;
          mAddr = ((mCyl * HEADS + mHead) * SECS + mSec) % (1 << ADDRW);
          if (mSec + 1 < SECS) mSec = mSec + 1;
          else begin
            mSec = 0;
            mHead = (mHead == HEADS - 1) ? 0 : mHead + 1;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      nCmp++;
      if (go !== mGo[0] || done !== mDone[0] || errCode !== mErr[3:0] ||
          headSec !== HSW'(mHead * (1 << SECW) + mSec) || driveCyl !== CYLW'(mCyl) ||
          busy !== mBusy[0] || secAddr !== ADDRW'(mAddr)) begin
        nBad++;
        $display("FAIL %s t=%0t go=%0b/%0d done=%0b/%0d err=%0h/%0h hs=%0h/%0h cyl=%0d/%0d busy=%0b/%0d addr=%0d/%0d",
          curReq, $time, go, mGo, done, mDone, errCode, mErr, headSec,
          mHead * (1 << SECW) + mSec, driveCyl, mCyl, busy, mBusy, secAddr, mAddr);
      end
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic doStart(int h, int s, int rq, int cc, logic [1:0] c, logic att, logic wp);
    @(posedge clk); #1;
    start = 1'b1; hsInit = HSW'(h * (1 << SECW) + s);
    reqCyl = CYLW'(rq); curCyl = CYLW'(cc); cmd = c; attached = att; writeProt = wp;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic doStep();
    @(posedge clk); #1; step = 1'b1;
    @(posedge clk); #1; step = 1'b0;
    @(negedge clk);
  endtask

  task automatic stepBurst(int n);
    @(posedge clk); #1; step = 1'b1;
    repeat (n) @(posedge clk);
    #1; step = 1'b0;
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog %s expired actual=running expected=finished", curReq);
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "go", 32'(go), 0);
    chk("R1", "done", 32'(done), 0);
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "errCode", 32'(errCode), 0);
    chk("R1", "headSec", 32'(headSec), 0);
    chk("R1", "secAddr", 32'(secAddr), 0);

    // R8 / R10 / R12: first sector at the origin is approved
    curReq = "R8";
    doStart(0, 0, 3, 3, 2'b00, 1'b1, 1'b0);
    doStep();
    chk("R12", "go on first origin step", 32'(go), 1);
    chk("R10", "secAddr", 32'(secAddr), 144);
    chk("R8", "headSec after inc", 32'(headSec), 1);

    // R9: run through every sector of every head, wrap to origin
    curReq = "R9";
    stepBurst(HEADS * SECS - 1);
    chk("R9", "headSec after full wrap", 32'(headSec), 0);
    chk("R9", "busy", 32'(busy), 1);

    // R6: overflow once the origin comes back
    curReq = "R6";
    doStep();
    chk("R6", "done", 32'(done), 1);
    chk("R6", "errCode", 32'(errCode), 8);
    chk("R11", "headSec held", 32'(headSec), 0);

    // R11: step while idle has no effect
    curReq = "R11";
    doStep();
    chk("R11", "go idle", 32'(go), 0);
    chk("R11", "done idle", 32'(done), 0);
    chk("R11", "busy idle", 32'(busy), 0);

    // R2: attach and write protection
    curReq = "R2";
    doStart(2, 5, 4, 4, 2'b00, 1'b0, 1'b0);
    doStep();
    chk("R2", "detached", 32'(errCode), 1);
    doStart(2, 5, 4, 4, 2'b01, 1'b1, 1'b1);
    doStep();
    chk("R2", "write protected", 32'(errCode), 1);
    doStart(2, 5, 4, 4, 2'b00, 1'b1, 1'b1);
    doStep();
    chk("R2", "read protected go", 32'(go), 1);
    chk("R10", "secAddr", 32'(secAddr), 221);
    doStart(2, 5, 4, 4, 2'b10, 1'b1, 1'b1);
    doStep();
    chk("R2", "read-check protected go", 32'(go), 1);

    // R3: cylinder compare fail
    curReq = "R3";
    doStart(1, 3, 5, 7, 2'b00, 1'b1, 1'b0);
    doStep();
    chk("R3", "errCode", 32'(errCode), 2);
    chk("R3", "headSec held", 32'(headSec), 19);
    chk("R3", "driveCyl held", 32'(driveCyl), 7);

    // R4: request of cylinder 0 forces the drive cylinder
    curReq = "R4";
    doStart(2, 11, 0, 9, 2'b01, 1'b1, 1'b0);
    doStep();
    chk("R4", "go", 32'(go), 1);
    chk("R4", "driveCyl", 32'(driveCyl), 0);
    chk("R4", "secAddr", 32'(secAddr), 35);
    chk("R9", "next surface", 32'(headSec), 48);

    // R5: sector overrun
    curReq = "R5";
    doStart(1, 12, 6, 6, 2'b00, 1'b1, 1'b0);
    doStep();
    chk("R5", "sector 12", 32'(errCode), 4);
    doStart(0, 15, 6, 6, 2'b10, 1'b1, 1'b0);
    doStep();
    chk("R5", "sector 15", 32'(errCode), 4);

    // R7: reporting order
    curReq = "R7";
    doStart(1, 13, 5, 8, 2'b01, 1'b0, 1'b0);
    doStep();
    chk("R7", "xfer over compare", 32'(errCode), 1);
    doStart(1, 13, 5, 8, 2'b00, 1'b1, 1'b0);
    doStep();
    chk("R7", "compare over overrun", 32'(errCode), 2);
    doStart(0, 14, 0, 8, 2'b00, 1'b1, 1'b0);
    doStep();
    chk("R7", "overrun after forcing", 32'(errCode), 4);
    chk("R7", "forced cylinder", 32'(driveCyl), 0);

    // R9: last head wraps, then overflow two steps later
    curReq = "R9";
    doStart(3, 11, 10, 10, 2'b10, 1'b1, 1'b0);
    doStep();
    chk("R9", "go", 32'(go), 1);
    chk("R9", "head wrap", 32'(headSec), 0);
    chk("R10", "secAddr", 32'(secAddr), 527);
    doStep();
    chk("R6", "overflow after wrap", 32'(errCode), 8);

    // R12: restart re-arms the first-sector mark
    curReq = "R12";
    doStart(0, 0, 2, 2, 2'b00, 1'b1, 1'b0);
    doStep();
    chk("R12", "first go", 32'(go), 1);
    doStart(0, 0, 2, 2, 2'b00, 1'b1, 1'b0);
    doStep();
    chk("R12", "go after restart", 32'(go), 1);
    chk("R12", "no fault after restart", 32'(errCode), 0);

    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule